// File: doc/BRIEF.md
# Floating-Point to Integer Converter with Selectable Rounding

This block turns a binary64 floating-point operand into a signed two's-complement integer of either 32 or 64 bits. One input picks the destination size per operation. The rounding mode is read live from the two lowest bits of a control/status word on every accepted operation. The result is registered, so it appears one cycle after the operand is presented.

Along with the integer, the block raises three one-cycle flag strobes: overflow, invalid operation and inexact. The surrounding control register ORs these into its sticky bits. A rounded value that does not fit the chosen width is an error, and so is a NaN or an infinity. On an error the integer output carries a fixed pattern, the largest positive value of the chosen width, and never a wrapped value.

Top module: `f2i_conv`

## Requirements
- R1: The rounding mode comes from `in_ctl[1:0]`, with 0 = nearest, 1 = toward zero, 2 = toward +infinity and 3 = toward -infinity. Bits `in_ctl[31:2]` have no effect on the result or on the flags.
- R2: In nearest mode, a value that is not exactly halfway between two integers goes to the closer integer. A value exactly halfway goes to the even integer (2.5 gives 2, -2.5 gives -2, 3.5 gives 4, -0.5 gives 0).
- R3: Toward-zero mode drops the fraction. Toward +infinity gives the ceiling and toward -infinity gives the floor (-1.25 gives -1 and -2 respectively).
- R4: `in_long`=1 selects a 64-bit destination with range [-2^63, 2^63-1]. `in_long`=0 selects a 32-bit destination with range [-2^31, 2^31-1], and its result is sign-extended to all 64 bits of `out_result`. Both sizes use the same rounding rules.
- R5: If the rounded value of a finite operand falls outside the destination range, overflow and invalid are both raised and inexact is not. `out_result` is then 0x000000007FFFFFFF for the 32-bit size or 0x7FFFFFFFFFFFFFFF for the 64-bit size.
- R6: A NaN or infinite operand raises invalid only, not overflow and not inexact, and gives the same constant as R5 for the selected size.
- R7: Inexact is raised exactly when the rounded integer differs from the operand and neither error of R5 or R6 applies.
- R8: An operation accepted with `in_valid`=1 at a clock edge gives `out_valid`=1 and its result and flags after that edge. Flags are one-cycle strobes and stay low whenever `out_valid` is low. `out_result` holds its value while `in_valid` is low.
- R9: While `rst_n` is low, `out_valid`, all three flags and `out_result` are zero.
- R10: Zero, negative zero and subnormal operands are converted like any other finite value. A nonzero subnormal is inexact and gives 1 when rounded toward +infinity if it is positive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_operand | input | 64 | binary64 source operand |
| in_long | input | 1 | 1 = 64-bit destination, 0 = 32-bit destination |
| in_ctl | input | 32 | Control/status word; bits [1:0] give the rounding mode |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 64 | Integer result (32-bit results sign-extended) |
| out_ovf | output | 1 | Overflow strobe |
| out_inv | output | 1 | Invalid-operation strobe |
| out_inx | output | 1 | Inexact strobe |

## Verification
The operand patterns are chosen to tell the four modes apart. Exact halves with odd and even integer parts, including negative and sub-unit ones, separate ties-to-even from round-half-up and from plain truncation. Fractions of 0.25 and 0.75 separate ceiling, floor and truncation on both signs. Values just inside and just outside each destination range tell the two sizes apart and check the asymmetric negative limit: 2^31-0.5, -2^31-0.5, ±2^31, ±2^63 and 2^52+1 in both sizes. NaN, infinity, signed zero, a subnormal and a very large exponent cover the special classes, and the control bits above the mode field are varied on every vector.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  // Rounding mode held in the two low bits of the control word.
  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  // Flag strobes produced per conversion.
  typedef struct packed {
    logic ovf;
    logic inv;
    logic inx;
  } flags_t;

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  localparam int FP_W = 1 + EXP_W + MAN_W
) (
  input  logic [FP_W-1:0]  operand,
  output logic             sign,
  output logic [EXP_W-1:0] exp_field,
  output logic [MAN_W:0]   sig,
  output logic             is_special,
  output logic             is_tiny
);

  logic [MAN_W-1:0] frac;

  always_comb begin
    sign       = operand[FP_W-1];
    exp_field  = operand[FP_W-2:MAN_W];
    frac       = operand[MAN_W-1:0];
    is_special = &exp_field;
    is_tiny    = ~|exp_field;
    // Hidden bit is present only for normal numbers.
    sig        = {~is_tiny, frac};
  end

endmodule

// File: rtl/f2i_align.sv
module f2i_align #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 64,
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1,
  localparam int POINT   = BIAS + MAN_W,
  localparam int LSH_MAX = INT_W - MAN_W,
  localparam int MAG_W   = MAN_W + LSH_MAX + 2,
  localparam int RSH_CAP = INT_W,
  localparam int BUF_W   = MAN_W + 1 + RSH_CAP,
  localparam int LSH_W   = $clog2(LSH_MAX + 1),
  localparam int RSH_W   = $clog2(RSH_CAP + 1)
) (
  input  logic [EXP_W-1:0] exp_field,
  input  logic [MAN_W:0]   sig,
  input  logic             is_tiny,
  output logic [MAG_W-1:0] mag,
  output logic             half,
  output logic             sticky,
  output logic             huge
);

  localparam logic [EXP_W:0] POINT_E = (EXP_W + 1)'(POINT);
  localparam logic [EXP_W:0] LSH_LIM = (EXP_W + 1)'(LSH_MAX);
  localparam logic [EXP_W:0] RSH_LIM = (EXP_W + 1)'(RSH_CAP);

  logic [EXP_W:0]   e_ext;
  logic             go_left;
  logic [EXP_W:0]   lsh;
  logic [EXP_W:0]   rsh;
  logic [LSH_W-1:0] lsh_c;
  logic [RSH_W-1:0] rsh_c;
  logic [MAG_W-1:0] left_vec;
  logic [BUF_W-1:0] right_buf;

  always_comb begin
    // Subnormals share the exponent of the smallest normal.
    e_ext   = is_tiny ? (EXP_W + 1)'(1) : {1'b0, exp_field};
    go_left = e_ext >= POINT_E;
    lsh     = e_ext - POINT_E;
    rsh     = POINT_E - e_ext;
    huge    = go_left && (lsh > LSH_LIM);
    lsh_c   = huge ? LSH_W'(0) : lsh[LSH_W-1:0];
    // Beyond RSH_CAP every significand bit already sits below the half bit.
    rsh_c   = (rsh > RSH_LIM) ? RSH_W'(RSH_CAP) : rsh[RSH_W-1:0];

    left_vec  = MAG_W'(sig) << lsh_c;
    right_buf = {sig, {RSH_CAP{1'b0}}} >> rsh_c;

    if (go_left) begin
      mag    = left_vec;
      half   = 1'b0;
      sticky = 1'b0;
    end else begin
      mag    = MAG_W'(right_buf[BUF_W-1:RSH_CAP]);
      half   = right_buf[RSH_CAP-1];
      sticky = |right_buf[RSH_CAP-2:0];
    end
  end

endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
#(
  parameter int MAG_W = 66
) (
  input  rmode_e           mode,
  input  logic             sign,
  input  logic [MAG_W-1:0] mag,
  input  logic             half,
  input  logic             sticky,
  output logic [MAG_W-1:0] mag_r,
  output logic             inexact
);

  logic lost;
  logic inc;

  always_comb begin
    lost = half | sticky;
    unique case (mode)
      RM_NEAR: inc = half & (sticky | mag[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = ~sign & lost;
      RM_DOWN: inc = sign & lost;
      default: inc = 1'b0;
    endcase
    mag_r   = mag + MAG_W'(inc);
    inexact = lost;
  end

endmodule

// File: rtl/f2i_range.sv
module f2i_range
  import f2i_pkg::*;
#(
  parameter int INT_W    = 64,
  parameter int NARROW_W = 32,
  parameter int MAG_W    = 66,
  localparam int N_DST   = 2
) (
  input  logic             sign,
  input  logic [MAG_W-1:0] mag_r,
  input  logic             huge,
  input  logic             is_special,
  input  logic             inexact,
  input  logic             long_sel,
  output logic [INT_W-1:0] result,
  output flags_t           flags
);

  logic [N_DST-1:0] fits;
  logic [INT_W-1:0] inv_pat [N_DST];

  // One range checker and one error pattern per destination size.
  for (genvar d = 0; d < N_DST; d++) begin : g_dst
    localparam int DW = (d == 1) ? INT_W : NARROW_W;
    localparam logic [MAG_W-1:0] NEG_LIM = MAG_W'(1) << (DW - 1);
    localparam logic [MAG_W-1:0] POS_LIM = NEG_LIM - MAG_W'(1);
    localparam logic [INT_W-1:0] PAT = INT_W'(POS_LIM);

    assign fits[d]    = sign ? (mag_r <= NEG_LIM) : (mag_r <= POS_LIM);
    assign inv_pat[d] = PAT;
  end

  logic [INT_W-1:0] twos;
  logic             range_err;
  logic             any_inv;

  always_comb begin
    twos      = sign ? (~mag_r[INT_W-1:0] + INT_W'(1)) : mag_r[INT_W-1:0];
    range_err = ~is_special & (huge | ~fits[long_sel]);
    any_inv   = is_special | range_err;
    flags.ovf = range_err;
    flags.inv = any_inv;
    flags.inx = inexact & ~any_inv;
    result    = any_inv ? inv_pat[long_sel] : twos;
  end

endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
  import f2i_pkg::*;
#(
  parameter int EXP_W    = 11,
  parameter int MAN_W    = 52,
  parameter int INT_W    = 64,
  parameter int NARROW_W = 32,
  parameter int CTL_W    = 32,
  localparam int FP_W    = 1 + EXP_W + MAN_W,
  localparam int MAG_W   = MAN_W + (INT_W - MAN_W) + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [FP_W-1:0]  in_operand,
  input  logic             in_long,
  input  logic [CTL_W-1:0] in_ctl,
  output logic             out_valid,
  output logic [INT_W-1:0] out_result,
  output logic             out_ovf,
  output logic             out_inv,
  output logic             out_inx
);

  logic             sign;
  logic [EXP_W-1:0] exp_field;
  logic [MAN_W:0]   sig;
  logic             is_special;
  logic             is_tiny;
  logic [MAG_W-1:0] mag;
  logic             half;
  logic             sticky;
  logic             huge;
  logic [MAG_W-1:0] mag_r;
  logic             inexact;
  logic [INT_W-1:0] conv_res;
  flags_t           conv_flags;
  rmode_e           mode;

  assign mode = rmode_e'(in_ctl[1:0]);

  f2i_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
    .operand    (in_operand),
    .sign       (sign),
    .exp_field  (exp_field),
    .sig        (sig),
    .is_special (is_special),
    .is_tiny    (is_tiny)
  );

  f2i_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_align (
    .exp_field (exp_field),
    .sig       (sig),
    .is_tiny   (is_tiny),
    .mag       (mag),
    .half      (half),
    .sticky    (sticky),
    .huge      (huge)
  );

  f2i_round #(.MAG_W(MAG_W)) u_round (
    .mode    (mode),
    .sign    (sign),
    .mag     (mag),
    .half    (half),
    .sticky  (sticky),
    .mag_r   (mag_r),
    .inexact (inexact)
  );

  f2i_range #(.INT_W(INT_W), .NARROW_W(NARROW_W), .MAG_W(MAG_W)) u_range (
    .sign       (sign),
    .mag_r      (mag_r),
    .huge       (huge),
    .is_special (is_special),
    .inexact    (inexact),
    .long_sel   (in_long),
    .result     (conv_res),
    .flags      (conv_flags)
  );

  // Next-state logic
  logic             valid_d;
  logic [INT_W-1:0] result_d;
  flags_t           flags_d;
  logic             result_en;

  always_comb begin
    valid_d   = in_valid;
    result_en = in_valid;
    result_d  = conv_res;
    flags_d   = in_valid ? conv_flags : '0;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ovf   <= 1'b0;
      out_inv   <= 1'b0;
      out_inx   <= 1'b0;
    end else begin
      out_valid <= valid_d;
      out_ovf   <= flags_d.ovf;
      out_inv   <= flags_d.inv;
      out_inx   <= flags_d.inx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_result <= '0;
    end else if (result_en) begin
      out_result <= result_d;
    end
  end

endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk #(
  parameter int INT_W    = 64,
  parameter int NARROW_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_long,
  input logic             out_valid,
  input logic [INT_W-1:0] out_result,
  input logic             out_ovf,
  input logic             out_inv,
  input logic             out_inx
);

  localparam logic [INT_W-1:0] PAT_LONG = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] PAT_WORD = INT_W'({1'b0, {(NARROW_W-1){1'b1}}});

  // R5
  overflow_implies_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovf |-> out_inv);

  // R7
  inexact_excludes_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_inv |-> !out_inx);

  // R8
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(out_ovf || out_inv || out_inx));

  // R8
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8
  idle_to_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_result));

  // R6
  invalid_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid ##1 out_inv |-> out_result == ($past(in_long) ? PAT_LONG : PAT_WORD));

  // R4
  word_sign_extended_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_long |=> out_result[INT_W-1:NARROW_W] == {(INT_W-NARROW_W){out_result[NARROW_W-1]}});

endmodule

bind f2i_conv f2i_conv_chk #(.INT_W(INT_W), .NARROW_W(NARROW_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_long    (in_long),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_ovf    (out_ovf),
  .out_inv    (out_inv),
  .out_inx    (out_inx)
);

// File: tb/tb_f2i_conv.sv
module tb_f2i_conv;

  localparam int PERIOD = 20;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_operand;
  logic        in_long;
  logic [31:0] in_ctl;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_ovf;
  logic        out_inv;
  logic        out_inx;

  int checks   = 0;
  int failures = 0;

  f2i_conv dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_operand (in_operand),
    .in_long    (in_long),
    .in_ctl     (in_ctl),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_ovf    (out_ovf),
    .out_inv    (out_inv),
    .out_inx    (out_inx)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // flags field order: {ovf, inv, inx}
  typedef struct packed {
    logic [63:0] op;
    logic        lng;
    logic [1:0]  mode;
    logic [63:0] res;
    logic [2:0]  flg;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    // R2 nearest, ties to even
    '{64'h3FF8000000000000, 1'b0, 2'd0, 64'h0000000000000002, 3'b001, 4'd2},
    '{64'h4004000000000000, 1'b0, 2'd0, 64'h0000000000000002, 3'b001, 4'd2},
    '{64'hC004000000000000, 1'b0, 2'd0, 64'hFFFFFFFFFFFFFFFE, 3'b001, 4'd2},
    '{64'h400C000000000000, 1'b1, 2'd0, 64'h0000000000000004, 3'b001, 4'd2},
    '{64'h3FE0000000000000, 1'b1, 2'd0, 64'h0000000000000000, 3'b001, 4'd2},
    '{64'hBFE0000000000000, 1'b0, 2'd0, 64'h0000000000000000, 3'b001, 4'd2},
    // R3 toward zero, ceiling, floor
    '{64'h4006000000000000, 1'b0, 2'd1, 64'h0000000000000002, 3'b001, 4'd3},
    '{64'hC006000000000000, 1'b0, 2'd1, 64'hFFFFFFFFFFFFFFFE, 3'b001, 4'd3},
    '{64'hBFF4000000000000, 1'b0, 2'd2, 64'hFFFFFFFFFFFFFFFF, 3'b001, 4'd3},
    '{64'hBFF4000000000000, 1'b0, 2'd3, 64'hFFFFFFFFFFFFFFFE, 3'b001, 4'd3},
    '{64'h4006000000000000, 1'b1, 2'd2, 64'h0000000000000003, 3'b001, 4'd3},
    '{64'h4006000000000000, 1'b1, 2'd3, 64'h0000000000000002, 3'b001, 4'd3},
    // R7 exact conversion
    '{64'h3FF0000000000000, 1'b0, 2'd2, 64'h0000000000000001, 3'b000, 4'd7},
    // R5 / R4 around the 32-bit limits
    '{64'h41DFFFFFFFE00000, 1'b0, 2'd0, 64'h000000007FFFFFFF, 3'b110, 4'd5},
    '{64'h41DFFFFFFFE00000, 1'b0, 2'd1, 64'h000000007FFFFFFF, 3'b001, 4'd4},
    '{64'h41DFFFFFFFE00000, 1'b1, 2'd0, 64'h0000000080000000, 3'b001, 4'd4},
    '{64'h41E0000000000000, 1'b0, 2'd1, 64'h000000007FFFFFFF, 3'b110, 4'd5},
    '{64'hC1E0000000000000, 1'b0, 2'd1, 64'hFFFFFFFF80000000, 3'b000, 4'd4},
    '{64'hC1E0000000100000, 1'b0, 2'd2, 64'hFFFFFFFF80000000, 3'b001, 4'd5},
    '{64'hC1E0000000100000, 1'b0, 2'd3, 64'h000000007FFFFFFF, 3'b110, 4'd5},
    // R5 / R4 around the 64-bit limits
    '{64'h43E0000000000000, 1'b1, 2'd1, 64'h7FFFFFFFFFFFFFFF, 3'b110, 4'd5},
    '{64'hC3E0000000000000, 1'b1, 2'd0, 64'h8000000000000000, 3'b000, 4'd4},
    '{64'h4330000000000001, 1'b1, 2'd0, 64'h0010000000000001, 3'b000, 4'd4},
    '{64'h4330000000000001, 1'b0, 2'd0, 64'h000000007FFFFFFF, 3'b110, 4'd5},
    // R6 NaN and infinity
    '{64'h7FF8000000000000, 1'b1, 2'd0, 64'h7FFFFFFFFFFFFFFF, 3'b010, 4'd6},
    '{64'hFFF0000000000000, 1'b0, 2'd3, 64'h000000007FFFFFFF, 3'b010, 4'd6},
    // R10 subnormal and signed zero
    '{64'h0000000000000001, 1'b0, 2'd2, 64'h0000000000000001, 3'b001, 4'd10},
    '{64'h0000000000000001, 1'b0, 2'd0, 64'h0000000000000000, 3'b001, 4'd10},
    '{64'h8000000000000000, 1'b1, 2'd3, 64'h0000000000000000, 3'b000, 4'd10},
    // R4 large exact, R5 far out of range
    '{64'h43D0000000000000, 1'b1, 2'd0, 64'h4000000000000000, 3'b000, 4'd4},
    '{64'h4700000000000000, 1'b1, 2'd0, 64'h7FFFFFFFFFFFFFFF, 3'b110, 4'd5}
  };

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n      = 1'b0;
    in_valid   = 1'b1;
    in_operand = 64'h3FF8000000000000;
    in_long    = 1'b0;
    in_ctl     = 32'h0;
    repeat (3) @(negedge clk);
    // R9 reset state even with a valid operand presented
    chk("R9 out_valid in reset", {63'd0, out_valid}, 64'd0);
    chk("R9 flags in reset", {61'd0, out_ovf, out_inv, out_inx}, 64'd0);
    chk("R9 result in reset", out_result, 64'd0);
    in_valid = 1'b0;
    rst_n    = 1'b1;
    @(negedge clk);
    chk("R8 idle after reset", {63'd0, out_valid}, 64'd0);

    // Table walk, back to back; R1: upper control bits vary per vector
    for (int i = 0; i < NV; i++) begin
      in_valid   = 1'b1;
      in_operand = VECS[i].op;
      in_long    = VECS[i].lng;
      in_ctl     = {i[29:0] ^ 30'h2AAAAAAA, VECS[i].mode};
      @(negedge clk);
      chk($sformatf("R%0d vec%0d result", VECS[i].req, i), out_result, VECS[i].res);
      chk($sformatf("R%0d vec%0d flags", VECS[i].req, i),
          {61'd0, out_ovf, out_inv, out_inx}, {61'd0, VECS[i].flg});
      chk($sformatf("R8 vec%0d valid", i), {63'd0, out_valid}, 64'd1);
    end

    // R1: same operand, only upper control bits changed, result identical
    in_operand = 64'h4004000000000000;
    in_long    = 1'b0;
    in_ctl     = 32'hFFFFFFFC;
    @(negedge clk);
    chk("R1 upper ctl bits ignored result", out_result, 64'h2);
    chk("R1 upper ctl bits ignored flags", {61'd0, out_ovf, out_inv, out_inx}, 64'b001);

    // R8: error strobe then idle; flags drop, result held
    in_operand = 64'h7FF0000000000000;
    in_long    = 1'b1;
    in_ctl     = 32'h0;
    @(negedge clk);
    chk("R6 +inf long flags", {61'd0, out_ovf, out_inv, out_inx}, 64'b010);
    in_valid   = 1'b0;
    in_operand = 64'h3FF0000000000000;
    in_long    = 1'b0;
    @(negedge clk);
    chk("R8 valid drops", {63'd0, out_valid}, 64'd0);
    chk("R8 flags drop", {61'd0, out_ovf, out_inv, out_inx}, 64'd0);
    chk("R8 result held", out_result, 64'h7FFFFFFFFFFFFFFF);
    @(negedge clk);
    chk("R8 result still held", out_result, 64'h7FFFFFFFFFFFFFFF);

    // R9: reset mid-stream clears outputs
    in_valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 async reset clears valid", {63'd0, out_valid}, 64'd0);
    chk("R9 async reset clears result", out_result, 64'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end

endmodule